// File: doc/BRIEF.md
# Pulse-Position Command Frame Decoder

This block recovers the bytes of a reader-to-card command sent with pulse-position coding. It consumes a stream of field samples, two per time slot. Each sample tells whether the carrier was dropped. The block hunts for a start delimiter after a quiet stretch. The start pattern selects one of two codings: four slots carrying two bits, or 256 slots carrying a whole byte. The block then turns each drop position into data and closes the frame when the end delimiter arrives.

Every recovered byte leaves on a one-cycle strobe together with its odd-parity bit. At the end of a frame the block pulses a done flag and presents the byte count. Any framing violation produces a one-cycle error pulse. After such a pulse the decoder returns to hunting and needs a fresh quiet run before it accepts another start. A frame that ends before its first byte yields a single marker byte instead of a done flag.

Top module: `ppm_cmd_decoder`

## Requirements
- R1: While idle, a drop sample starts a frame only when it follows at least 8 consecutive valid no-drop samples; otherwise the drop is ignored and the count restarts.
- R2: After the start phase, a drop in the first half of a slot is an error unless exactly one slot of the current symbol window has completed.
- R3: The start drop is the first half of slot 1 of a 4-slot start window. A second-half drop in slot 3 selects 1-of-4 coding, one in slot 4 selects 1-of-256 coding, and any other outcome is an error.
- R4: In 1-of-4 coding, a second-half drop in slot k (k = 1..4) gives the bit pair k-1. The first pair of a byte lands in bits 1:0 and the fourth pair in bits 7:6. A byte is emitted after every fourth pair.
- R5: In 1-of-256 coding, a second-half drop in slot k (k = 1..256) gives the byte value k-1.
- R6: Two drops in one symbol window, or a window that closes with no drop, raise an error.
- R7: A first-half drop after exactly one completed slot ends the frame: frame_done_o pulses for one cycle and frame_len_o equals the number of bytes emitted in that frame.
- R8: An end delimiter before any byte emits a single byte 0xF0 (with its parity bit) and no frame_done_o.
- R9: parity_o is 1 exactly when byte_o holds an even number of ones, so the nine bits together have odd weight.
- R10: frame_len_o stops at 32. Further bytes are discarded without a strobe, and error_o pulses in the same cycle as frame_done_o.
- R11: error_o is a single-cycle pulse. After it the decoder is idle and again needs the full quiet run of R1.
- R12: Cycles with sample_valid_i low change no state, whatever drop_i holds, and produce no strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Qualifies drop_i for this cycle |
| drop_i | input | 1 | 1 when the field is dropped in this sample |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o and parity_o |
| byte_o | output | 8 | Recovered byte |
| parity_o | output | 1 | Odd-parity bit for byte_o |
| frame_done_o | output | 1 | One-cycle pulse at a valid end of frame |
| frame_len_o | output | 6 | Bytes emitted in the current or last frame |
| error_o | output | 1 | One-cycle framing or overflow error pulse |

## Verification
The end-of-frame flag and the error flag meet in one cycle only when a frame overruns the 32-byte limit. The bench provokes this by sending 34 bytes in 1-of-4 coding and then the end delimiter. It judges that exactly 32 strobes appear, that the done pulse carries a length of 32, and that the error pulse lands on that same cycle and no other. A second pairing has a byte strobe against the 0xF0 marker at an empty end delimiter. There the bench confirms that the marker comes without any done pulse.

// File: rtl/ppm_dec_pkg.sv
package ppm_dec_pkg;
  localparam int SHORT_SLOTS = 4;
  localparam int LONG_SLOTS  = 256;
  localparam int SLOT_W      = $clog2(LONG_SLOTS + 1);
  localparam int POS_W       = $clog2(LONG_SLOTS);
  localparam logic [7:0] EMPTY_MARK = 8'hF0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SOF,
    ST_Q4,
    ST_Q256
  } dec_state_e;

  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/ppm_quiet_det.sv
module ppm_quiet_det #(
  parameter int RUN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic smp_vld_i,
  input  logic drop_i,
  output logic armed_o
);
  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (hold_i)             cnt_q <= '0;
    else if (smp_vld_i) begin
      if (drop_i)                cnt_q <= '0;
      else if (cnt_q != CW'(RUN)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign armed_o = (cnt_q == CW'(RUN));
endmodule

// File: rtl/ppm_slot_trk.sv
module ppm_slot_trk
  import ppm_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic              smp_vld_i,
  input  logic              drop_i,
  input  logic [SLOT_W-1:0] win_len_i,
  output logic              fh_drop_o,
  output logic              win_end_o,
  output logic              dbl_o,
  output logic              hit_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              at_one_o
);
  logic              half_q, seen_q;
  logic [SLOT_W-1:0] slot_q, slot_nx;
  logic [POS_W-1:0]  pos_q;
  logic              smp, sh;

  assign smp       = smp_vld_i && run_i;
  assign sh        = smp && half_q;
  assign slot_nx   = slot_q + 1'b1;
  assign fh_drop_o = smp && !half_q && drop_i;
  assign win_end_o = sh && (slot_nx == win_len_i);
  assign dbl_o     = sh && drop_i && seen_q;
  assign hit_o     = seen_q || drop_i;
  assign pos_o     = (drop_i && !seen_q) ? slot_q[POS_W-1:0] : pos_q;
  assign at_one_o  = (slot_q == SLOT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      seen_q <= 1'b0;
      slot_q <= '0;
      pos_q  <= '0;
    end else if (start_i) begin
      // start drop was the first half of slot 1
      half_q <= 1'b1;
      seen_q <= 1'b0;
      slot_q <= '0;
      pos_q  <= '0;
    end else if (!run_i) begin
      half_q <= 1'b0;
      seen_q <= 1'b0;
      slot_q <= '0;
    end else if (sh) begin
      half_q <= 1'b0;
      if (win_end_o) begin
        slot_q <= '0;
        seen_q <= 1'b0;
      end else begin
        slot_q <= slot_nx;
        if (drop_i && !seen_q) begin
          pos_q  <= slot_q[POS_W-1:0];
          seen_q <= 1'b1;
        end
      end
    end else if (smp) begin
      half_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ppm_pair_asm.sv
module ppm_pair_asm #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          pair_vld_i,
  input  logic [1:0]    pair_i,
  output logic          done_o,
  output logic [BW-1:0] byte_o
);
  localparam int NP = BW / 2;
  localparam int CW = (NP > 1) ? $clog2(NP) : 1;

  logic [BW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  // newest pair enters at the top, first pair ends in bits 1:0
  assign byte_o = {pair_i, sh_q[BW-1:2]};
  assign done_o = pair_vld_i && (cnt_q == CW'(NP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (pair_vld_i) begin
      sh_q  <= done_o ? '0 : byte_o;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ppm_cmd_decoder.sv
module ppm_cmd_decoder
  import ppm_dec_pkg::*;
#(
  parameter int QUIET_RUN = 8,
  parameter int MAX_LEN   = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           sample_valid_i,
  input  logic                           drop_i,
  output logic                           byte_valid_o,
  output logic [7:0]                     byte_o,
  output logic                           parity_o,
  output logic                           frame_done_o,
  output logic [$clog2(MAX_LEN+1)-1:0]   frame_len_o,
  output logic                           error_o
);
  localparam int LW = $clog2(MAX_LEN + 1);

  dec_state_e        state_q, st_d;
  logic              armed, start, run;
  logic              fh_drop, win_end, dbl, hit, at_one;
  logic [POS_W-1:0]  pos;
  logic [SLOT_W-1:0] win_len;
  logic              pair_vld, asm_done, byte_done;
  logic [7:0]        asm_byte, byte_val;
  logic              ev_err, ev_end;
  logic [LW-1:0]     len_q;
  logic              ovf_q;

  assign run     = (state_q != ST_IDLE);
  assign start   = sample_valid_i && !run && drop_i && armed;
  assign win_len = (state_q == ST_Q256) ? SLOT_W'(LONG_SLOTS) : SLOT_W'(SHORT_SLOTS);

  ppm_quiet_det #(.RUN(QUIET_RUN)) i_quiet (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (run),
    .smp_vld_i (sample_valid_i),
    .drop_i    (drop_i),
    .armed_o   (armed)
  );

  ppm_slot_trk i_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .run_i     (run),
    .smp_vld_i (sample_valid_i),
    .drop_i    (drop_i),
    .win_len_i (win_len),
    .fh_drop_o (fh_drop),
    .win_end_o (win_end),
    .dbl_o     (dbl),
    .hit_o     (hit),
    .pos_o     (pos),
    .at_one_o  (at_one)
  );

  assign pair_vld = (state_q == ST_Q4) && win_end && !dbl && hit;

  ppm_pair_asm #(.BW(8)) i_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start || !run),
    .pair_vld_i (pair_vld),
    .pair_i     (pos[1:0]),
    .done_o     (asm_done),
    .byte_o     (asm_byte)
  );

  assign byte_done = asm_done ||
                     ((state_q == ST_Q256) && win_end && !dbl && hit);
  assign byte_val  = (state_q == ST_Q256) ? pos[7:0] : asm_byte;

  always_comb begin
    st_d   = state_q;
    ev_err = 1'b0;
    ev_end = 1'b0;
    if (sample_valid_i) begin
      unique case (state_q)
        ST_IDLE: if (start) st_d = ST_SOF;
        ST_SOF: begin
          if (dbl) ev_err = 1'b1;
          else if (win_end) begin
            if (hit && pos == POS_W'(2))      st_d = ST_Q4;
            else if (hit && pos == POS_W'(3)) st_d = ST_Q256;
            else                              ev_err = 1'b1;
          end
        end
        ST_Q4, ST_Q256: begin
          if (fh_drop) begin
            if (at_one) ev_end = 1'b1;
            else        ev_err = 1'b1;
          end else if (dbl)             ev_err = 1'b1;
          else if (win_end && !hit)     ev_err = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
    if (ev_err || ev_end) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
      parity_o     <= 1'b0;
      frame_done_o <= 1'b0;
      error_o      <= 1'b0;
      len_q        <= '0;
      ovf_q        <= 1'b0;
    end else begin
      state_q      <= st_d;
      byte_valid_o <= 1'b0;
      frame_done_o <= 1'b0;
      error_o      <= 1'b0;
      if (start) begin
        len_q <= '0;
        ovf_q <= 1'b0;
      end
      if (byte_done) begin
        if (len_q != LW'(MAX_LEN)) begin
          byte_valid_o <= 1'b1;
          byte_o       <= byte_val;
          parity_o     <= odd_par(byte_val);
          len_q        <= len_q + 1'b1;
        end else begin
          ovf_q <= 1'b1;
        end
      end
      if (ev_end) begin
        if (len_q == '0) begin
          byte_valid_o <= 1'b1;
          byte_o       <= EMPTY_MARK;
          parity_o     <= odd_par(EMPTY_MARK);
        end else begin
          frame_done_o <= 1'b1;
          error_o      <= ovf_q;
        end
      end
      if (ev_err) error_o <= 1'b1;
    end
  end

  assign frame_len_o = len_q;
endmodule

// File: rtl/ppm_cmd_decoder_chk.sv
module ppm_cmd_decoder_chk #(
  parameter int MAX_LEN = 32,
  parameter int LW      = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sample_valid_i,
  input logic          byte_valid_o,
  input logic          frame_done_o,
  input logic [LW-1:0] frame_len_o,
  input logic          error_o
);
  a_r11_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> !error_o);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  a_r10_len_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_len_o <= LW'(MAX_LEN));

  a_r8_byte_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> !frame_done_o);

  a_r10_len_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && frame_len_o != '0) |-> frame_len_o == $past(frame_len_o) + 1'b1);

  a_r12_gap_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> (!byte_valid_o && !frame_done_o && !error_o));
endmodule

bind ppm_cmd_decoder ppm_cmd_decoder_chk #(
  .MAX_LEN (MAX_LEN),
  .LW      ($clog2(MAX_LEN + 1))
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .byte_valid_o   (byte_valid_o),
  .frame_done_o   (frame_done_o),
  .frame_len_o    (frame_len_o),
  .error_o        (error_o)
);

// File: tb/test_ppm_cmd_decoder.sv
module test_ppm_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_valid = 1'b0;
  logic       drop = 1'b0;
  logic       byte_valid_o, parity_o, frame_done_o, error_o;
  logic [7:0] byte_o;
  logic [5:0] frame_len_o;

  int n_chk = 0, n_fail = 0;
  int nb = 0, nd = 0, ne = 0, done_err = 0, last_len = 0;
  logic [7:0] cap_b [64];
  logic       cap_p [64];
  bit gap_en = 0;
  int gap_k = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppm_cmd_decoder i_ppm_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sample_valid), .drop_i(drop),
    .byte_valid_o(byte_valid_o), .byte_o(byte_o), .parity_o(parity_o),
    .frame_done_o(frame_done_o), .frame_len_o(frame_len_o), .error_o(error_o)
  );

  always @(negedge clk) if (rst_n) begin
    if (byte_valid_o) begin
      if (nb < 64) begin cap_b[nb] = byte_o; cap_p[nb] = parity_o; end
      nb++;
    end
    if (frame_done_o) begin
      nd++;
      last_len = int'(frame_len_o);
      if (error_o) done_err++;
    end
    if (error_o) ne++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_caps();
    nb = 0; nd = 0; ne = 0; done_err = 0; last_len = 0;
  endtask

  task automatic idle(input int n);
    @(negedge clk); sample_valid = 1'b0; drop = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic smp(input logic d);
    if (gap_en && (gap_k++ % 5 == 0)) begin
      @(negedge clk); sample_valid = 1'b0; drop = 1'b1;
    end
    @(negedge clk); sample_valid = 1'b1; drop = d;
  endtask

  task automatic quiet(input int n);
    repeat (n) smp(1'b0);
  endtask

  task automatic arm();
    smp(1'b1); quiet(8);
  endtask

  // long=1: drop in slot 4 (1-of-256), else slot 3 (1-of-4)
  task automatic sof(input bit long);
    smp(1'b1); smp(1'b0);
    smp(1'b0); smp(1'b0);
    smp(1'b0); smp(!long);
    smp(1'b0); smp(long);
  endtask

  task automatic symbol(input int slots, input int v);
    for (int k = 0; k < slots; k++) begin
      smp(1'b0); smp(k == v);
    end
  endtask

  task automatic byte4(input logic [7:0] b);
    for (int k = 0; k < 4; k++) symbol(4, int'(b[2*k +: 2]));
  endtask

  task automatic eof();
    smp(1'b0); smp(1'b1); smp(1'b1);
    quiet(4);
  endtask

  function automatic int exp_par(input logic [7:0] b);
    return int'(~^b);
  endfunction

  task automatic t_reset();
    chk("R11 reset error_o", int'(error_o), 0);
    chk("R7 reset frame_done_o", int'(frame_done_o), 0);
    chk("R7 reset frame_len_o", int'(frame_len_o), 0);
    chk("R8 reset byte_valid_o", int'(byte_valid_o), 0);
  endtask

  task automatic t_q4();
    logic [7:0] d [3] = '{8'h0A, 8'hC5, 8'h3C};
    clear_caps(); arm(); sof(0);
    foreach (d[i]) byte4(d[i]);
    eof(); idle(3);
    chk("R4 q4 byte count", nb, 3);
    foreach (d[i]) begin
      chk("R4 q4 byte value", int'(cap_b[i]), int'(d[i]));
      chk("R9 q4 parity", int'(cap_p[i]), exp_par(d[i]));
    end
    chk("R7 q4 done", nd, 1);
    chk("R7 q4 frame_len", last_len, 3);
    chk("R3 q4 no error", ne, 0);
  endtask

  task automatic t_q256();
    int d [3] = '{0, 255, 129};
    clear_caps(); arm(); sof(1);
    foreach (d[i]) symbol(256, d[i]);
    eof(); idle(3);
    chk("R5 q256 byte count", nb, 3);
    foreach (d[i]) begin
      chk("R5 q256 byte value", int'(cap_b[i]), d[i]);
      chk("R9 q256 parity", int'(cap_p[i]), exp_par(8'(d[i])));
    end
    chk("R7 q256 frame_len", last_len, 3);
    chk("R3 q256 no error", ne, 0);
  endtask

  task automatic t_gap();
    clear_caps(); gap_en = 1; gap_k = 0;
    arm(); sof(0); byte4(8'h96); byte4(8'h21); eof();
    gap_en = 0; idle(3);
    chk("R12 gap byte count", nb, 2);
    chk("R12 gap byte0", int'(cap_b[0]), 8'h96);
    chk("R12 gap byte1", int'(cap_b[1]), 8'h21);
    chk("R12 gap done", nd, 1);
    chk("R12 gap no error", ne, 0);
  endtask

  task automatic t_guard();
    clear_caps(); smp(1'b1); quiet(7); sof(0); eof(); idle(3);
    chk("R1 short quiet no byte", nb, 0);
    chk("R1 short quiet no done", nd, 0);
    chk("R1 short quiet no error", ne, 0);
  endtask

  task automatic t_marker();
    clear_caps(); arm(); sof(0); eof(); idle(3);
    chk("R8 marker count", nb, 1);
    chk("R8 marker value", int'(cap_b[0]), 8'hF0);
    chk("R9 marker parity", int'(cap_p[0]), 1);
    chk("R8 marker no done", nd, 0);
  endtask

  task automatic t_bad_sof();
    clear_caps(); arm();
    smp(1'b1); smp(1'b0); smp(1'b0); smp(1'b1);
    smp(1'b0); smp(1'b0); smp(1'b0); smp(1'b0);
    idle(3);
    chk("R3 bad start error", ne, 1);
    chk("R3 bad start no byte", nb, 0);
    clear_caps(); quiet(3); sof(0); eof(); idle(3);
    chk("R11 rearm needs quiet", nb, 0);
    chk("R11 rearm no error", ne, 0);
  endtask

  task automatic t_double();
    clear_caps(); smp(1'b1); idle(1); arm(); sof(0); byte4(8'h55);
    smp(1'b0); smp(1'b1); smp(1'b0); smp(1'b1);
    quiet(4); idle(3);
    chk("R6 double drop byte", nb, 1);
    chk("R6 double drop error", ne, 1);
    chk("R6 double drop no done", nd, 0);
  endtask

  task automatic t_empty();
    clear_caps(); smp(1'b1); idle(1); arm(); sof(0);
    quiet(8); quiet(4); idle(3);
    chk("R6 empty window error", ne, 1);
    chk("R6 empty window no byte", nb, 0);
  endtask

  task automatic t_fh();
    clear_caps(); smp(1'b1); idle(1); arm(); sof(0); byte4(8'h0F);
    smp(1'b0); smp(1'b0); smp(1'b0); smp(1'b0); smp(1'b1);
    quiet(4); idle(3);
    chk("R2 late half drop error", ne, 1);
    chk("R2 late half drop no done", nd, 0);
    chk("R2 late half drop byte", nb, 1);
  endtask

  task automatic t_ovf();
    clear_caps(); smp(1'b1); idle(1); arm(); sof(0);
    for (int i = 0; i < 34; i++) byte4(8'(i + 3));
    eof(); idle(3);
    chk("R10 overflow strobes", nb, 32);
    chk("R10 overflow last kept", int'(cap_b[31]), 34);
    chk("R10 overflow done", nd, 1);
    chk("R10 overflow frame_len", last_len, 32);
    chk("R10 overflow error with done", done_err, 1);
    chk("R10 overflow single error", ne, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_q4();
    t_q256();
    t_gap();
    t_guard();
    t_marker();
    t_bad_sof();
    t_double();
    t_empty();
    t_fh();
    t_ovf();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule